// File: doc/BRIEF.md
# 1-Wire ROM-Layer Slave

This block is the slave side of a single-wire bus. It works on an oversampled copy of the data line and pulls the line low through an open-drain enable. It detects bus resets and answers each one with a presence pulse. It decodes the master's write slots and drives read slots. On top of this bit layer it runs the 64-bit address commands: read address, match, skip, search and resume.

Once an address command succeeds, the block enters the function phase. There it hands every received byte to a function-command port and sends bytes that the port supplies. The address is a parameter. Time is measured by counting a one-per-microsecond clock enable, so every duration parameter is given in microseconds.

Top module: `owire_rom_slave`

## Requirements
- R1: A low level of at least RST_MIN_US ticks that then returns high is a bus reset and triggers a presence pulse. A shorter low triggers none.
- R2: After the rising edge of a bus reset, the slave waits PD_WAIT_US ticks and then holds the line low for exactly PD_LOW_US ticks.
- R3: Each slot starts at a falling edge of the line. The slave samples the line SAMPLE_US ticks later: high is a 1 and low is a 0.
- R4: To send a 0, the slave drives the line low from the slot's falling edge for HOLD_US ticks. To send a 1, it does not drive.
- R5: The read-address opcode is 33h when rd_op_alt is 0 and 39h when it is 1; the other value is treated as unknown. After it, the slave sends all 64 address bits LSB first and then enters the function phase.
- R6: Match (55h) takes 64 bits from the master. If every bit equals the address, the slave enters the function phase. On the first differing bit it goes idle.
- R7: Search (F0h) repeats three slots for each address bit: the slave sends the bit, then its complement, then reads the master's bit. A differing master bit makes it go idle. After all 64 bits it enters the function phase.
- R8: Skip (CCh) enters the function phase directly.
- R9: Resume (A5h) enters the function phase only when the resume flag is set; otherwise the slave goes idle. A completed match or search sets the flag. A failed match or search, a skip, or a read-address clears it.
- R10: An unknown opcode, and the state after power-up, leave the slave idle until the next bus reset. While idle it never drives the line in slots and fn_active stays 0.
- R11: In the function phase, each 8 sampled bits form one byte, LSB first. The byte appears on fn_rx_byte with a single-cycle fn_rx_valid. While fn_tx_en is 1, the slave sends fn_tx_byte LSB first in the same slots.
- R12: A bus reset aborts any transaction. fn_active falls at the reset's rising edge and the slave waits for a new opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | Clock enable, one pulse per microsecond |
| dq_in | input | 1 | Raw data line level |
| rd_op_alt | input | 1 | Selects 39h instead of 33h as the read-address opcode |
| fn_tx_en | input | 1 | Function phase: send fn_tx_byte in the coming slots |
| fn_tx_byte | input | 8 | Byte sent in the function phase, LSB first |
| dq_oe | output | 1 | Open-drain enable; 1 pulls the line low |
| fn_active | output | 1 | Function phase is active |
| fn_rx_byte | output | 8 | Last byte assembled in the function phase |
| fn_rx_valid | output | 1 | One-cycle strobe for fn_rx_byte |

## Verification
The bench ties us_tick high and builds the block with RST_MIN_US=40, PD_WAIT_US=4, PD_LOW_US=12, SAMPLE_US=8 and HOLD_US=10, so one microsecond equals one clock and a slot lasts 24 clocks. With a bus this short, the bench can send every one of the 256 byte values through the function phase. It can also place a match mismatch at bit positions spread across the whole 64-bit address and cover every resume-flag history, all within the run budget. Presence delay and width are predicted from the sync and register latency and compared to the cycle.

// File: rtl/owr_pkg.sv
package owr_pkg;
    typedef enum logic [2:0] {
        RS_DEAD,
        RS_CMD,
        RS_READ,
        RS_MATCH,
        RS_SEARCH,
        RS_FUNC
    } rom_st_e;

    typedef enum logic [1:0] {
        PR_IDLE,
        PR_WAIT,
        PR_DRIVE
    } pres_st_e;

    localparam logic [7:0] OP_RD_STD = 8'h33;
    localparam logic [7:0] OP_RD_ALT = 8'h39;
    localparam logic [7:0] OP_MATCH  = 8'h55;
    localparam logic [7:0] OP_SEARCH = 8'hF0;
    localparam logic [7:0] OP_SKIP   = 8'hCC;
    localparam logic [7:0] OP_RESUME = 8'hA5;
endpackage

// File: rtl/owr_line.sv
module owr_line #(
    parameter int unsigned RST_MIN_US = 480,
    parameter int unsigned PD_WAIT_US = 30,
    parameter int unsigned PD_LOW_US  = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic dq_raw,
    output logic dq_s,
    output logic bus_rst,
    output logic slot_fall,
    output logic pres_oe
);
    import owr_pkg::*;

    localparam int unsigned LW   = $clog2(RST_MIN_US + 1);
    localparam int unsigned PMAX = (PD_WAIT_US > PD_LOW_US) ? PD_WAIT_US : PD_LOW_US;
    localparam int unsigned PW   = $clog2(PMAX + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          prev;
        logic [LW-1:0] low_cnt;
        pres_st_e      pst;
        logic [PW-1:0] pcnt;
    } line_t;

    line_t q, d;
    logic fell, rose, rst_evt;

    always_comb begin
        d       = q;
        d.s1    = dq_raw;
        d.s2    = q.s1;
        d.prev  = q.s2;
        fell    = q.prev & ~q.s2;
        rose    = ~q.prev & q.s2;
        rst_evt = rose && (q.low_cnt == LW'(RST_MIN_US));

        // low-time measurement, saturating at the reset threshold
        if (q.s2) begin
            d.low_cnt = '0;
        end else if (tick && (q.low_cnt != LW'(RST_MIN_US))) begin
            d.low_cnt = q.low_cnt + 1'b1;
        end

        // presence sequencer
        if (rst_evt) begin
            d.pst  = PR_WAIT;
            d.pcnt = '0;
        end else if (tick) begin
            case (q.pst)
                PR_WAIT: begin
                    if (q.pcnt == PW'(PD_WAIT_US - 1)) begin
                        d.pst  = PR_DRIVE;
                        d.pcnt = '0;
                    end else begin
                        d.pcnt = q.pcnt + 1'b1;
                    end
                end
                PR_DRIVE: begin
                    if (q.pcnt == PW'(PD_LOW_US - 1)) begin
                        d.pst  = PR_IDLE;
                        d.pcnt = '0;
                    end else begin
                        d.pcnt = q.pcnt + 1'b1;
                    end
                end
                default: d.pcnt = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1      <= 1'b1;
            q.s2      <= 1'b1;
            q.prev    <= 1'b1;
            q.low_cnt <= '0;
            q.pst     <= PR_IDLE;
            q.pcnt    <= '0;
        end else begin
            q <= d;
        end
    end

    assign dq_s      = q.s2;
    assign bus_rst   = rst_evt;
    assign slot_fall = fell && (q.pst == PR_IDLE);
    assign pres_oe   = (q.pst == PR_DRIVE);
endmodule

// File: rtl/owr_slot.sv
module owr_slot #(
    parameter int unsigned SAMPLE_US = 30,
    parameter int unsigned HOLD_US   = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic dq_s,
    input  logic bus_rst,
    input  logic slot_fall,
    input  logic tx_bit,
    output logic slot_oe,
    output logic bit_valid,
    output logic rx_bit
);
    localparam int unsigned END_US = (SAMPLE_US > HOLD_US) ? SAMPLE_US : HOLD_US;
    localparam int unsigned CW     = $clog2(END_US + 1);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
        logic          drv;
        logic          rxb;
        logic          bv;
    } slot_t;

    slot_t q, d;
    logic [CW-1:0] cnt_n;

    always_comb begin
        d     = q;
        d.bv  = 1'b0;
        cnt_n = q.cnt + 1'b1;
        if (bus_rst) begin
            d.act = 1'b0;
            d.drv = 1'b0;
            d.cnt = '0;
        end else if (slot_fall) begin
            d.act = 1'b1;
            d.cnt = '0;
            d.drv = ~tx_bit;
        end else if (q.act && tick) begin
            d.cnt = cnt_n;
            if (cnt_n == CW'(SAMPLE_US)) begin
                d.bv  = 1'b1;
                d.rxb = dq_s;
            end
            if (cnt_n == CW'(HOLD_US)) begin
                d.drv = 1'b0;
            end
            if (cnt_n == CW'(END_US)) begin
                d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign slot_oe   = q.drv;
    assign bit_valid = q.bv;
    assign rx_bit    = q.rxb;
endmodule

// File: rtl/owr_rom.sv
module owr_rom #(
    parameter int unsigned ID_BITS = 64,
    parameter logic [ID_BITS-1:0] NET_ID = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst,
    input  logic       bit_valid,
    input  logic       rx_bit,
    input  logic       rd_op_alt,
    input  logic       fn_tx_en,
    input  logic [7:0] fn_tx_byte,
    output logic       tx_bit,
    output logic       fn_active,
    output logic [7:0] fn_rx_byte,
    output logic       fn_rx_valid
);
    import owr_pkg::*;

    localparam int unsigned IW = $clog2(ID_BITS);

    typedef struct packed {
        rom_st_e       st;
        logic [IW-1:0] cnt;
        logic [1:0]    phase;
        logic [7:0]    sh;
        logic          resume;
        logic          rxv;
        logic [7:0]    rxbyte;
    } rom_t;

    rom_t q, d;
    logic [7:0] byte_n;
    logic [7:0] rd_op;
    logic       id_bit;
    logic       last;

    always_comb begin
        id_bit = NET_ID[q.cnt];
        case (q.st)
            RS_READ:   tx_bit = id_bit;
            RS_SEARCH: tx_bit = (q.phase == 2'd0) ? id_bit :
                                (q.phase == 2'd1) ? ~id_bit : 1'b1;
            RS_FUNC:   tx_bit = fn_tx_en ? fn_tx_byte[q.cnt[2:0]] : 1'b1;
            default:   tx_bit = 1'b1;
        endcase
    end

    always_comb begin
        d      = q;
        d.rxv  = 1'b0;
        byte_n = {rx_bit, q.sh[7:1]};
        rd_op  = rd_op_alt ? OP_RD_ALT : OP_RD_STD;
        last   = (q.cnt == IW'(ID_BITS - 1));
        if (bus_rst) begin
            d.st    = RS_CMD;
            d.cnt   = '0;
            d.phase = 2'd0;
        end else if (bit_valid) begin
            case (q.st)
                RS_CMD: begin
                    d.sh = byte_n;
                    if (q.cnt[2:0] == 3'd7) begin
                        d.cnt   = '0;
                        d.phase = 2'd0;
                        if (byte_n == rd_op) begin
                            d.st     = RS_READ;
                            d.resume = 1'b0;
                        end else begin
                            case (byte_n)
                                OP_MATCH:  d.st = RS_MATCH;
                                OP_SEARCH: d.st = RS_SEARCH;
                                OP_SKIP: begin
                                    d.st     = RS_FUNC;
                                    d.resume = 1'b0;
                                end
                                OP_RESUME: d.st = q.resume ? RS_FUNC : RS_DEAD;
                                default:   d.st = RS_DEAD;
                            endcase
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RS_READ: begin
                    if (last) begin
                        d.st  = RS_FUNC;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RS_MATCH: begin
                    if (rx_bit != id_bit) begin
                        d.st     = RS_DEAD;
                        d.resume = 1'b0;
                    end else if (last) begin
                        d.st     = RS_FUNC;
                        d.resume = 1'b1;
                        d.cnt    = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RS_SEARCH: begin
                    case (q.phase)
                        2'd0: d.phase = 2'd1;
                        2'd1: d.phase = 2'd2;
                        default: begin
                            d.phase = 2'd0;
                            if (rx_bit != id_bit) begin
                                d.st     = RS_DEAD;
                                d.resume = 1'b0;
                            end else if (last) begin
                                d.st     = RS_FUNC;
                                d.resume = 1'b1;
                                d.cnt    = '0;
                            end else begin
                                d.cnt = q.cnt + 1'b1;
                            end
                        end
                    endcase
                end
                RS_FUNC: begin
                    d.sh = byte_n;
                    if (q.cnt[2:0] == 3'd7) begin
                        d.cnt    = '0;
                        d.rxv    = 1'b1;
                        d.rxbyte = byte_n;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= RS_DEAD;
            q.cnt    <= '0;
            q.phase  <= 2'd0;
            q.sh     <= '0;
            q.resume <= 1'b0;
            q.rxv    <= 1'b0;
            q.rxbyte <= '0;
        end else begin
            q <= d;
        end
    end

    assign fn_active   = (q.st == RS_FUNC);
    assign fn_rx_byte  = q.rxbyte;
    assign fn_rx_valid = q.rxv;
endmodule

// File: rtl/owire_rom_slave.sv
module owire_rom_slave #(
    parameter int unsigned ID_BITS    = 64,
    parameter logic [ID_BITS-1:0] NET_ID = 64'h5E00_0000_0000_0001,
    parameter int unsigned RST_MIN_US = 480,
    parameter int unsigned PD_WAIT_US = 30,
    parameter int unsigned PD_LOW_US  = 120,
    parameter int unsigned SAMPLE_US  = 30,
    parameter int unsigned HOLD_US    = 45
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       dq_in,
    input  logic       rd_op_alt,
    input  logic       fn_tx_en,
    input  logic [7:0] fn_tx_byte,
    output logic       dq_oe,
    output logic       fn_active,
    output logic [7:0] fn_rx_byte,
    output logic       fn_rx_valid
);
    logic dq_s, bus_rst, slot_fall, pres_oe;
    logic slot_oe, bit_valid, rx_bit, tx_bit;

    owr_line #(
        .RST_MIN_US(RST_MIN_US),
        .PD_WAIT_US(PD_WAIT_US),
        .PD_LOW_US (PD_LOW_US)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (us_tick),
        .dq_raw   (dq_in),
        .dq_s     (dq_s),
        .bus_rst  (bus_rst),
        .slot_fall(slot_fall),
        .pres_oe  (pres_oe)
    );

    owr_slot #(
        .SAMPLE_US(SAMPLE_US),
        .HOLD_US  (HOLD_US)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (us_tick),
        .dq_s     (dq_s),
        .bus_rst  (bus_rst),
        .slot_fall(slot_fall),
        .tx_bit   (tx_bit),
        .slot_oe  (slot_oe),
        .bit_valid(bit_valid),
        .rx_bit   (rx_bit)
    );

    owr_rom #(
        .ID_BITS(ID_BITS),
        .NET_ID (NET_ID)
    ) u_rom (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rst    (bus_rst),
        .bit_valid  (bit_valid),
        .rx_bit     (rx_bit),
        .rd_op_alt  (rd_op_alt),
        .fn_tx_en   (fn_tx_en),
        .fn_tx_byte (fn_tx_byte),
        .tx_bit     (tx_bit),
        .fn_active  (fn_active),
        .fn_rx_byte (fn_rx_byte),
        .fn_rx_valid(fn_rx_valid)
    );

    assign dq_oe = pres_oe | slot_oe;
endmodule

// File: rtl/owire_rom_slave_chk.sv
module owire_rom_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_rst,
    input logic dq_s,
    input logic pres_oe,
    input logic slot_oe,
    input logic slot_fall,
    input logic bit_valid,
    input logic fn_active,
    input logic fn_rx_valid
);
    // R1
    reset_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |-> (dq_s && !$past(dq_s)));

    // R2
    presence_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pres_oe |-> !slot_oe);

    // R4
    drive_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_oe) |-> $past(slot_fall));

    // R8
    func_entry_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fn_active) |-> $past(bit_valid));

    // R11
    rx_strobe_in_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fn_rx_valid |-> $past(fn_active));

    // R12
    abort_on_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !fn_active);
endmodule

bind owire_rom_slave owire_rom_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rst    (bus_rst),
    .dq_s       (dq_s),
    .pres_oe    (pres_oe),
    .slot_oe    (slot_oe),
    .slot_fall  (slot_fall),
    .bit_valid  (bit_valid),
    .fn_active  (fn_active),
    .fn_rx_valid(fn_rx_valid)
);

// File: tb/owire_rom_slave_tb.sv
module owire_rom_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RST_MIN    = 40;
    localparam int PD_WAIT    = 4;
    localparam int PD_LOW     = 12;
    localparam int SAMPLE     = 8;
    localparam int HOLD       = 10;
    localparam int SLOT       = 24;
    localparam logic [63:0] ID = 64'h9D_5A3C96E1F00D_2B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_low = 1'b0;
    logic       rd_op_alt = 1'b0;
    logic       fn_tx_en = 1'b0;
    logic [7:0] fn_tx_byte = 8'h00;
    logic       dq_oe, fn_active, fn_rx_valid;
    logic [7:0] fn_rx_byte;
    logic       dq_line;
    int         n_vec = 0;
    int         n_bad = 0;
    int         rx_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    bit         done = 1'b0;

    assign dq_line = ~(m_low | dq_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    owire_rom_slave #(
        .ID_BITS   (64),
        .NET_ID    (ID),
        .RST_MIN_US(RST_MIN),
        .PD_WAIT_US(PD_WAIT),
        .PD_LOW_US (PD_LOW),
        .SAMPLE_US (SAMPLE),
        .HOLD_US   (HOLD)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .us_tick    (1'b1),
        .dq_in      (dq_line),
        .rd_op_alt  (rd_op_alt),
        .fn_tx_en   (fn_tx_en),
        .fn_tx_byte (fn_tx_byte),
        .dq_oe      (dq_oe),
        .fn_active  (fn_active),
        .fn_rx_byte (fn_rx_byte),
        .fn_rx_valid(fn_rx_valid)
    );

    always @(negedge clk) begin
        if (fn_rx_valid) begin
            rx_cnt  = rx_cnt + 1;
            rx_last = fn_rx_byte;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_bit(input bit b);
        m_low = 1'b1;
        wait_n(b ? 2 : 16);
        m_low = 1'b0;
        wait_n(b ? SLOT - 2 : SLOT - 16);
    endtask

    task automatic rd_bit(output bit r);
        m_low = 1'b1;
        wait_n(2);
        m_low = 1'b0;
        wait_n(4);
        r = dq_line;
        wait_n(SLOT - 6);
    endtask

    task automatic wr_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wr_bit(v[i]);
    endtask

    task automatic rd_byte(output logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            bit r;
            rd_bit(r);
            v[i] = r;
        end
    endtask

    // low pulse of len cycles, then watch the line for 40 cycles
    task automatic pulse(input int len, output int first, output int lows);
        m_low = 1'b1;
        wait_n(len);
        m_low = 1'b0;
        first = 0;
        lows  = 0;
        for (int i = 1; i <= 40; i++) begin
            wait_n(1);
            if (!dq_line) begin
                lows++;
                if (first == 0) first = i;
            end
        end
    endtask

    task automatic bus_reset();
        int f, l;
        pulse(RST_MIN + 8, f, l);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int f, l, k0;
        logic [7:0] b;
        logic [63:0] got;
        bit r0, r1;

        wait_n(5);
        check(dq_oe == 1'b0, "R10 reset dq_oe", dq_oe, 0);
        check(fn_active == 1'b0, "R10 reset fn_active", fn_active, 0);
        rst_n = 1'b1;
        wait_n(3);

        // idle after power-up: reads give all ones
        rd_byte(b);
        check(b == 8'hFF, "R10 idle before first reset", b, 8'hFF);

        // short pulse is no reset
        pulse(RST_MIN - 20, f, l);
        check(l == 0, "R1 short low no presence", l, 0);

        // real reset: presence timing
        pulse(RST_MIN + 8, f, l);
        check(l == PD_LOW, "R2 presence width", l, PD_LOW);
        check(f >= PD_WAIT + 1 && f <= PD_WAIT + 4, "R2 presence delay", f, PD_WAIT + 3);
        check(l != 0, "R1 long low gives presence", l, PD_LOW);

        // read address, standard opcode
        wr_byte(8'h33);
        for (int i = 0; i < 8; i++) begin
            rd_byte(b);
            got[i*8 +: 8] = b;
        end
        check(got == ID, "R5 read address 33h", got, ID);
        check(fn_active == 1'b1, "R5 function after read", fn_active, 1);

        // function writes: every byte value
        for (int v = 0; v < 256; v++) begin
            int c0;
            c0 = rx_cnt;
            wr_byte(8'(v));
            check(rx_cnt == c0 + 1 && rx_last == 8'(v), "R3 R11 write byte", {rx_cnt - c0, rx_last}, {1, 8'(v)});
        end

        // function reads
        fn_tx_en = 1'b1;
        for (int v = 0; v < 256; v += 17) begin
            fn_tx_byte = 8'(v ^ 8'h5A);
            rd_byte(b);
            check(b == fn_tx_byte, "R4 R11 read byte", b, fn_tx_byte);
        end
        fn_tx_en = 1'b0;

        // reset aborts
        bus_reset();
        check(fn_active == 1'b0, "R12 reset aborts function", fn_active, 0);

        // alternate opcode selection
        rd_op_alt = 1'b1;
        wr_byte(8'h33);
        rd_byte(b);
        check(b == 8'hFF && !fn_active, "R5 33h unknown when alt", {fn_active, b}, 8'hFF);
        bus_reset();
        wr_byte(8'h39);
        for (int i = 0; i < 8; i++) begin
            rd_byte(b);
            got[i*8 +: 8] = b;
        end
        check(got == ID, "R5 read address 39h", got, ID);
        rd_op_alt = 1'b0;

        // match success then resume
        bus_reset();
        wr_byte(8'h55);
        for (int i = 0; i < 64; i++) wr_bit(ID[i]);
        check(fn_active == 1'b1, "R6 match ok", fn_active, 1);
        bus_reset();
        wr_byte(8'hA5);
        check(fn_active == 1'b1, "R9 resume after match", fn_active, 1);

        // read address clears resume flag
        bus_reset();
        wr_byte(8'h33);
        for (int i = 0; i < 8; i++) rd_byte(b);
        bus_reset();
        wr_byte(8'hA5);
        check(fn_active == 1'b0, "R9 resume cleared by read", fn_active, 0);

        // match mismatch sweep
        for (int k = 0; k < 64; k += 3) begin
            bus_reset();
            wr_byte(8'h55);
            for (int i = 0; i <= k; i++) wr_bit((i == k) ? ~ID[i] : ID[i]);
            rd_byte(b);
            check(!fn_active && b == 8'hFF, "R6 match mismatch", {fn_active, b}, 8'hFF);
        end
        bus_reset();
        wr_byte(8'hA5);
        check(fn_active == 1'b0, "R9 resume after failed match", fn_active, 0);

        // full search
        bus_reset();
        wr_byte(8'hF0);
        k0 = 0;
        for (int i = 0; i < 64; i++) begin
            rd_bit(r0);
            rd_bit(r1);
            if (r0 != ID[i] || r1 != ~ID[i]) k0++;
            wr_bit(ID[i]);
        end
        check(k0 == 0, "R7 search bit and complement", k0, 0);
        check(fn_active == 1'b1, "R7 search complete", fn_active, 1);
        bus_reset();
        wr_byte(8'hA5);
        check(fn_active == 1'b1, "R9 resume after search", fn_active, 1);

        // search drop-out
        bus_reset();
        wr_byte(8'hF0);
        for (int i = 0; i < 20; i++) begin
            rd_bit(r0);
            rd_bit(r1);
            wr_bit((i == 19) ? ~ID[i] : ID[i]);
        end
        rd_byte(b);
        check(!fn_active && b == 8'hFF, "R7 search mismatch", {fn_active, b}, 8'hFF);
        bus_reset();
        wr_byte(8'hA5);
        check(fn_active == 1'b0, "R9 resume after failed search", fn_active, 0);

        // skip, then resume after skip
        bus_reset();
        wr_byte(8'hCC);
        check(fn_active == 1'b1, "R8 skip", fn_active, 1);
        bus_reset();
        wr_byte(8'hA5);
        check(fn_active == 1'b0, "R9 resume cleared by skip", fn_active, 0);

        // unknown opcode
        bus_reset();
        wr_byte(8'h96);
        rd_byte(b);
        check(!fn_active && b == 8'hFF, "R10 unknown opcode", {fn_active, b}, 8'hFF);
        bus_reset();
        wr_byte(8'hCC);
        check(fn_active == 1'b1, "R10 R12 recovery after reset", fn_active, 1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule